// File: doc/BRIEF.md
# NAND Flash Operation Engine

The engine sits between a simple register port and the pins of a NAND flash device. Software loads a flash command byte, an address byte or a buffer index into registers. It then starts one bus phase by writing a single one-hot operation bit into the control register. The engine runs that phase on the flash pins with its own strobe timing. It moves page, ID or status bytes between the flash and an internal byte-wide buffer RAM, then reports completion through a done bit and an interrupt line.

The buffer RAM is split into `NUM_BUFS` regions. Each region is `BUF_BYTES` of main data followed by `SPARE_BYTES` of spare data. A large page is moved as one transfer per region, selected by the buffer index. The flash ready/busy line is handled inside the engine, so software only ever watches the done bit. A flash reset command completes differently: the control register returns to all zeros and the done bit stays clear. Software reaches the buffer RAM through a separate byte port.

Top module: `nand_op_engine`

## Requirements
- R1: Register addresses are command byte 0, address byte 1, buffer index 2, control 3 and configuration 4. Writing control bit 0 asserts CLE and drives the command byte on DQ during one WE# low pulse of `PULSE_CYC` clocks, followed by `HOLD_CYC` clocks of hold.
- R2: Writing control bit 1 runs the same cycle with ALE instead of CLE and drives the address byte.
- R3: Control bit 2 waits for ready, then drives `BUF_BYTES+SPARE_BYTES` bytes from the selected region onto DQ, one per WE# pulse with CLE and ALE low. Control bit 3 reads the same number of bytes into that region, each sampled in the last clock of its RE# low pulse.
- R4: Control bit 4 reads `ID_BYTES` bytes and control bit 5 reads one byte. Both write to buffer RAM offset 0 whatever the buffer index is, and leave the following bytes unchanged.
- R5: When a phase completes, the control register reads 0x8000: bit 15 is set and the operation bits are clear. Writing the control register with bit 15 at 0 while idle clears bit 15. After reset the control register reads 0.
- R6: A command-latch phase whose command byte is 0xFF waits for ready after its hold time. It then leaves the control register at 0x0000 with bit 15 clear.
- R7: The buffer index selects the RAM region that starts at byte `index*(BUF_BYTES+SPARE_BYTES)`.
- R8: With configuration bit 2 set, a page transfer moves only the `SPARE_BYTES` spare bytes, at region offset `BUF_BYTES`, and leaves the main bytes untouched.
- R9: `irq_o` is high exactly when control bit 15 is set and configuration bit 4 (interrupt mask) is clear.
- R10: Chip enable is low during every phase and whenever configuration bit 7 is set, and high otherwise.
- R11: Writing configuration bit 6 aborts any phase and clears the control register; bit 6 reads back as 0. Configuration bits 2, 3, 4 and 7 read back as written.
- R12: While a phase is busy, writes to the control register are ignored. The control register reads the active operation bit during that time. A control write with zero or several operation bits set starts nothing.
- R13: Page and ID/status phases issue no read or data-write strobe while ready/busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| buf_we_i | input | 1 | Buffer RAM host write strobe |
| buf_addr_i | input | BUF_AW | Buffer RAM host byte address |
| buf_wdata_i | input | 8 | Buffer RAM host write data |
| buf_rdata_o | output | 8 | Buffer RAM host read data |
| irq_o | output | 1 | Completion interrupt |
| nand_ce_no | output | 1 | Flash chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to flash |
| nand_dq_oe_o | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data from flash |
| nand_rb_i | input | 1 | Flash ready (1) / busy (0) |

## Verification
Several properties are checked on every cycle by assertions: the read and write strobes never overlap, CLE and ALE are never both high, at most one operation bit is active, and the done bit is never set while a phase runs. The assertions also check that a control write during a phase leaves the operation unchanged, that no strobe follows a busy cycle in the ready wait, and that chip enable is low under any strobe. Byte-level results can only be shown by the bench's scenarios. These are the values on DQ for each latch cycle, the buffer region and offsets that a page, spare-only, ID or status read fills, the all-zero completion of a flash reset, and the abort by soft reset.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_RDY, ST_STROBE, ST_GAP, ST_RST_WAIT
  } phase_e;

  localparam int OP_CMD   = 0;
  localparam int OP_ADDR  = 1;
  localparam int OP_DIN   = 2;
  localparam int OP_DOUT  = 3;
  localparam int OP_ID    = 4;
  localparam int OP_STAT  = 5;
  localparam int NUM_OPS  = 6;
  localparam int DONE_BIT = 15;

  localparam int CFG_SPARE = 2;
  localparam int CFG_ECC   = 3;
  localparam int CFG_IMASK = 4;
  localparam int CFG_SRST  = 6;
  localparam int CFG_FCE   = 7;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_BIDX = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_CFG  = 3'd4;

  localparam logic [7:0] FLASH_RESET_CMD = 8'hFF;
endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_eng_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       cmd_byte_o,
  output logic [7:0]       addr_byte_o,
  output logic [IDX_W-1:0] buf_idx_o,
  output logic             spare_only_o,
  output logic             irq_mask_o,
  output logic             force_ce_o,
  output logic             soft_rst_o,
  output logic [15:0]      cfg_rd_o
);
  logic ecc_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_byte_o   <= '0;
      addr_byte_o  <= '0;
      buf_idx_o    <= '0;
      spare_only_o <= 1'b0;
      ecc_en_q     <= 1'b0;
      irq_mask_o   <= 1'b0;
      force_ce_o   <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        RA_CMD:  cmd_byte_o  <= wdata_i;
        RA_ADDR: addr_byte_o <= wdata_i;
        RA_BIDX: buf_idx_o   <= wdata_i[IDX_W-1:0];
        RA_CFG: begin
          spare_only_o <= wdata_i[CFG_SPARE];
          ecc_en_q     <= wdata_i[CFG_ECC];
          irq_mask_o   <= wdata_i[CFG_IMASK];
          force_ce_o   <= wdata_i[CFG_FCE];
        end
        default: ;
      endcase
    end
  end

  // self-clearing: a pulse only
  assign soft_rst_o = we_i && (addr_i == RA_CFG) && wdata_i[CFG_SRST];

  always_comb begin
    cfg_rd_o            = '0;
    cfg_rd_o[CFG_SPARE] = spare_only_o;
    cfg_rd_o[CFG_ECC]   = ecc_en_q;
    cfg_rd_o[CFG_IMASK] = irq_mask_o;
    cfg_rd_o[CFG_FCE]   = force_ce_o;
  end
endmodule

// File: rtl/nand_buf_ram.sv
module nand_buf_ram #(
  parameter int DEPTH = 2112,
  parameter int AW    = 12
) (
  input  logic          clk_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [7:0]    h_wdata_i,
  output logic [7:0]    h_rdata_o,
  input  logic          e_we_i,
  input  logic [AW-1:0] e_addr_i,
  input  logic [7:0]    e_wdata_i,
  output logic [7:0]    e_rdata_o
);
  logic [7:0] mem_q [DEPTH];

  // engine write wins over a same-cycle host write
  always_ff @(posedge clk_i) begin
    if (e_we_i)      mem_q[e_addr_i] <= e_wdata_i;
    else if (h_we_i) mem_q[h_addr_i] <= h_wdata_i;
  end

  assign h_rdata_o = mem_q[h_addr_i];
  assign e_rdata_o = mem_q[e_addr_i];
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_eng_pkg::*;
#(
  parameter int BUF_BYTES   = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NUM_BUFS    = 4,
  parameter int ID_BYTES    = 6,
  parameter int PULSE_CYC   = 2,
  parameter int HOLD_CYC    = 2,
  parameter int AW          = 12,
  parameter int IDX_W       = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [NUM_OPS-1:0] ctrl_op_i,
  input  logic               ctrl_done_wr_i,
  input  logic               soft_rst_i,
  input  logic [7:0]         cmd_byte_i,
  input  logic [7:0]         addr_byte_i,
  input  logic [IDX_W-1:0]   buf_idx_i,
  input  logic               spare_only_i,
  input  logic               rb_i,
  input  logic [7:0]         dq_i,
  input  logic [7:0]         ram_rdata_i,
  output logic [15:0]        ctrl_o,
  output logic               busy_o,
  output logic               ram_we_o,
  output logic [AW-1:0]      ram_addr_o,
  output logic [7:0]         ram_wdata_o,
  output logic               cle_o,
  output logic               ale_o,
  output logic               we_no,
  output logic               re_no,
  output logic [7:0]         dq_o,
  output logic               dq_oe_o
);
  localparam int REGION = BUF_BYTES + SPARE_BYTES;
  localparam int CW     = $clog2(REGION);
  localparam int TW     = $clog2(PULSE_CYC + HOLD_CYC) + 1;
  localparam logic [AW-1:0] REGION_A = AW'(REGION);

  phase_e             st_q;
  logic [NUM_OPS-1:0] op_q;
  logic               done_q;
  logic [TW-1:0]      tmr_q;
  logic [CW-1:0]      cnt_q, last_q, start_last;
  logic [AW-1:0]      base_q, start_base;
  logic               start, is_wr, is_rd, in_beat, pulse_end, hold_end;

  assign start = ctrl_we_i && (st_q == ST_IDLE) && $onehot(ctrl_op_i) && !soft_rst_i;

  always_comb begin
    start_base = '0;
    start_last = '0;
    if (ctrl_op_i[OP_DIN] || ctrl_op_i[OP_DOUT]) begin
      start_base = AW'(buf_idx_i) * REGION_A + (spare_only_i ? AW'(BUF_BYTES) : '0);
      start_last = spare_only_i ? CW'(SPARE_BYTES - 1) : CW'(REGION - 1);
    end else if (ctrl_op_i[OP_ID]) begin
      start_last = CW'(ID_BYTES - 1);
    end
  end

  assign pulse_end = (tmr_q == TW'(PULSE_CYC - 1));
  assign hold_end  = (tmr_q == TW'(HOLD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      done_q <= 1'b0;
      tmr_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      base_q <= '0;
    end else if (soft_rst_i) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      done_q <= 1'b0;
      tmr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            op_q   <= ctrl_op_i;
            done_q <= 1'b0;
            base_q <= start_base;
            last_q <= start_last;
            cnt_q  <= '0;
            tmr_q  <= '0;
            st_q   <= (ctrl_op_i[OP_CMD] || ctrl_op_i[OP_ADDR]) ? ST_STROBE : ST_WAIT_RDY;
          end else if (ctrl_we_i && !ctrl_done_wr_i) begin
            done_q <= 1'b0;
          end
        end
        ST_WAIT_RDY: if (rb_i) begin
          tmr_q <= '0;
          st_q  <= ST_STROBE;
        end
        ST_STROBE: begin
          if (pulse_end) begin
            tmr_q <= '0;
            st_q  <= ST_GAP;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_GAP: begin
          if (hold_end) begin
            tmr_q <= '0;
            if (cnt_q == last_q) begin
              if (op_q[OP_CMD] && cmd_byte_i == FLASH_RESET_CMD) st_q <= ST_RST_WAIT;
              else begin
                op_q   <= '0;
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
              st_q  <= ST_STROBE;
            end
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_RST_WAIT: if (rb_i) begin
          op_q <= '0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign is_wr   = op_q[OP_CMD] | op_q[OP_ADDR] | op_q[OP_DIN];
  assign is_rd   = op_q[OP_DOUT] | op_q[OP_ID] | op_q[OP_STAT];
  assign in_beat = (st_q == ST_STROBE) || (st_q == ST_GAP);

  assign cle_o   = op_q[OP_CMD] && in_beat;
  assign ale_o   = op_q[OP_ADDR] && in_beat;
  assign we_no   = !(is_wr && st_q == ST_STROBE);
  assign re_no   = !(is_rd && st_q == ST_STROBE);
  assign dq_oe_o = is_wr && in_beat;
  assign dq_o    = op_q[OP_CMD] ? cmd_byte_i : (op_q[OP_ADDR] ? addr_byte_i : ram_rdata_i);

  assign ram_addr_o  = base_q + AW'(cnt_q);
  assign ram_we_o    = is_rd && (st_q == ST_STROBE) && pulse_end;
  assign ram_wdata_o = dq_i;

  assign busy_o = |op_q;
  assign ctrl_o = {done_q, {(15 - NUM_OPS){1'b0}}, op_q};

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  p_latch_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_op_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_q));
  p_busy_ignore_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_we_i && !soft_rst_i) |=> (op_q == $past(op_q) || op_q == '0));
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (op_q == '0));
  p_rdy_gate_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_RDY && !rb_i && !soft_rst_i) |=> (we_no && re_no));
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
  import nand_eng_pkg::*;
#(
  parameter int BUF_BYTES   = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NUM_BUFS    = 4,
  parameter int ID_BYTES    = 6,
  parameter int PULSE_CYC   = 2,
  parameter int HOLD_CYC    = 2,
  parameter int BUF_AW      = $clog2(NUM_BUFS * (BUF_BYTES + SPARE_BYTES))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              buf_we_i,
  input  logic [BUF_AW-1:0] buf_addr_i,
  input  logic [7:0]        buf_wdata_i,
  output logic [7:0]        buf_rdata_o,
  output logic              irq_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb_i
);
  localparam int DEPTH = NUM_BUFS * (BUF_BYTES + SPARE_BYTES);
  localparam int IDX_W = $clog2(NUM_BUFS);

  logic [7:0]        cmd_byte, addr_byte, ram_wdata, ram_rdata;
  logic [IDX_W-1:0]  buf_idx;
  logic              spare_only, irq_mask, force_ce, soft_rst, busy, ram_we, ctrl_we;
  logic [15:0]       cfg_rd, ctrl_q;
  logic [BUF_AW-1:0] ram_addr;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[14:8];
  assign ctrl_we      = reg_we_i && (reg_addr_i == RA_CTRL);

  nand_cfg_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i[7:0]),
    .cmd_byte_o  (cmd_byte),
    .addr_byte_o (addr_byte),
    .buf_idx_o   (buf_idx),
    .spare_only_o(spare_only),
    .irq_mask_o  (irq_mask),
    .force_ce_o  (force_ce),
    .soft_rst_o  (soft_rst),
    .cfg_rd_o    (cfg_rd)
  );

  nand_phase_fsm #(
    .BUF_BYTES(BUF_BYTES), .SPARE_BYTES(SPARE_BYTES), .NUM_BUFS(NUM_BUFS),
    .ID_BYTES(ID_BYTES), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .AW(BUF_AW), .IDX_W(IDX_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .ctrl_we_i     (ctrl_we),
    .ctrl_op_i     (reg_wdata_i[NUM_OPS-1:0]),
    .ctrl_done_wr_i(reg_wdata_i[DONE_BIT]),
    .soft_rst_i    (soft_rst),
    .cmd_byte_i    (cmd_byte),
    .addr_byte_i   (addr_byte),
    .buf_idx_i     (buf_idx),
    .spare_only_i  (spare_only),
    .rb_i          (nand_rb_i),
    .dq_i          (nand_dq_i),
    .ram_rdata_i   (ram_rdata),
    .ctrl_o        (ctrl_q),
    .busy_o        (busy),
    .ram_we_o      (ram_we),
    .ram_addr_o    (ram_addr),
    .ram_wdata_o   (ram_wdata),
    .cle_o         (nand_cle_o),
    .ale_o         (nand_ale_o),
    .we_no         (nand_we_no),
    .re_no         (nand_re_no),
    .dq_o          (nand_dq_o),
    .dq_oe_o       (nand_dq_oe_o)
  );

  nand_buf_ram #(.DEPTH(DEPTH), .AW(BUF_AW)) u_ram (
    .clk_i,
    .h_we_i   (buf_we_i),
    .h_addr_i (buf_addr_i),
    .h_wdata_i(buf_wdata_i),
    .h_rdata_o(buf_rdata_o),
    .e_we_i   (ram_we),
    .e_addr_i (ram_addr),
    .e_wdata_i(ram_wdata),
    .e_rdata_o(ram_rdata)
  );

  always_comb begin
    case (reg_addr_i)
      RA_CMD:  reg_rdata_o = {8'h00, cmd_byte};
      RA_ADDR: reg_rdata_o = {8'h00, addr_byte};
      RA_BIDX: reg_rdata_o = 16'(buf_idx);
      RA_CTRL: reg_rdata_o = ctrl_q;
      RA_CFG:  reg_rdata_o = cfg_rd;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o      = ctrl_q[DONE_BIT] && !irq_mask;
  assign nand_ce_no = !(busy || force_ce);

  p_ce_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);
  p_oe_on_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> nand_dq_oe_o);
  p_no_oe_on_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
endmodule

// File: tb/nand_op_engine_bench.sv
module nand_op_engine_bench;
  localparam int BB = 16, SB = 4, NB = 4, IDB = 4;
  localparam int REGION = BB + SB;
  localparam int AW = $clog2(NB * REGION);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0, buf_we = 1'b0, rb = 1'b1;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata, dq_o, dq_i;
  logic irq, ce_n, cle, ale, we_n, re_n, dq_oe;

  always #10 clk = ~clk;

  nand_op_engine #(
    .BUF_BYTES(BB), .SPARE_BYTES(SB), .NUM_BUFS(NB), .ID_BYTES(IDB),
    .PULSE_CYC(2), .HOLD_CYC(2)
  ) u_nand_op_engine (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata), .buf_rdata_o(buf_rdata),
    .irq_o(irq), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(dq_i), .nand_rb_i(rb)
  );

  // flash model: log latched bytes, feed read data
  logic [9:0] logv [256];
  int log_n = 0, rd_n = 0, bad_strobe = 0;
  int checks = 0, errors = 0;

  always @(posedge we_n) if (rst_ni && log_n < 256) begin
    logv[log_n] = {cle, ale, dq_o};
    log_n = log_n + 1;
  end
  always @(posedge re_n) if (rst_ni) rd_n = rd_n + 1;
  always @(negedge re_n) if (rst_ni && !rb) bad_strobe = bad_strobe + 1;
  always @(negedge we_n) if (rst_ni && !rb && !cle && !ale) bad_strobe = bad_strobe + 1;
  assign dq_i = 8'h40 + rd_n[7:0];

  // {is_addr, byte}: latch-cycle vectors
  localparam logic [8:0] VEC [4] = '{9'h000, 9'h112, 9'h134, 9'h030};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic buf_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic buf_rd(input int a, output logic [7:0] v);
    buf_addr = AW'(a); #1; v = buf_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_rd(3'd3, v);
      if (v[5:0] == 6'h00) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] b;
    int n0, r0, bad;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    reg_rd(3'd3, v); chk(v, 16'h0000, "R5 reset control");
    chk(irq, 0, "R9 reset irq");
    chk({ce_n, we_n, re_n}, 3'b111, "R10 reset strobes");

    // vector table: latch cycles
    foreach (VEC[k]) begin
      reg_wr(VEC[k][8] ? 3'd1 : 3'd0, {8'h00, VEC[k][7:0]});
      n0 = log_n;
      reg_wr(3'd3, VEC[k][8] ? 16'h0002 : 16'h0001);
      wait_idle();
      chk(log_n - n0, 1, "R1 R2 one strobe per latch cycle");
      chk(logv[n0], {~VEC[k][8], VEC[k][8], VEC[k][7:0]}, VEC[k][8] ? "R2 address latch" : "R1 command latch");
      reg_rd(3'd3, v); chk(v, 16'h8000, "R5 done bit");
      chk(irq, 1, "R9 irq on done");
      reg_wr(3'd3, 16'h0000);
      reg_rd(3'd3, v); chk(v, 16'h0000, "R5 done cleared");
      chk(irq, 0, "R9 irq after clear");
    end

    // interrupt mask
    reg_wr(3'd4, 16'h0010);
    reg_rd(3'd4, v); chk(v, 16'h0010, "R11 mask readback");
    reg_wr(3'd3, 16'h0001);
    wait_idle();
    reg_rd(3'd3, v); chk(v, 16'h8000, "R5 done while masked");
    chk(irq, 0, "R9 masked irq");
    reg_wr(3'd4, 16'h0008);
    reg_rd(3'd4, v); chk(v, 16'h0008, "R11 ecc bit readback");
    chk(irq, 1, "R9 irq after unmask");
    reg_wr(3'd3, 16'h0000);
    reg_wr(3'd4, 16'h0000);

    // page data in from buffer 1, gated by ready, busy writes ignored
    for (int i = 0; i < REGION; i++) buf_wr(REGION + i, 8'hC0 + 8'(i));
    reg_wr(3'd2, 16'h0001);
    rb = 1'b0;
    n0 = log_n;
    reg_wr(3'd3, 16'h0004);
    repeat (10) @(negedge clk);
    chk(log_n - n0, 0, "R13 no write strobe while busy");
    chk(ce_n, 0, "R10 chip enable during phase");
    reg_wr(3'd3, 16'h0008);
    reg_rd(3'd3, v); chk(v, 16'h0004, "R12 busy write ignored");
    rb = 1'b1;
    wait_idle();
    chk(log_n - n0, REGION, "R3 data-in byte count");
    bad = 0;
    for (int i = 0; i < REGION; i++)
      if (logv[n0 + i] !== {2'b00, 8'hC0 + 8'(i)}) bad++;
    chk(bad, 0, "R3 R7 data-in bytes from region 1");
    chk(bad_strobe, 0, "R13 strobes while busy");
    reg_rd(3'd3, v); chk(v, 16'h8000, "R5 data-in done");
    reg_wr(3'd3, 16'h0000);

    // page data out into buffer 2
    reg_wr(3'd2, 16'h0002);
    r0 = rd_n;
    reg_wr(3'd3, 16'h0008);
    wait_idle();
    bad = 0;
    for (int i = 0; i < REGION; i++) begin
      buf_rd(2 * REGION + i, b);
      if (b !== 8'h40 + 8'(r0 + i)) bad++;
    end
    chk(bad, 0, "R3 R7 data-out into region 2");
    buf_rd(REGION, b); chk(b, 8'hC0, "R7 region 1 untouched");
    reg_wr(3'd3, 16'h0000);

    // spare-only read into buffer 3
    for (int i = 0; i < REGION; i++) buf_wr(3 * REGION + i, 8'h00);
    reg_wr(3'd2, 16'h0003);
    reg_wr(3'd4, 16'h0004);
    r0 = rd_n;
    reg_wr(3'd3, 16'h0008);
    wait_idle();
    chk(rd_n - r0, SB, "R8 spare-only read count");
    bad = 0;
    for (int i = 0; i < REGION; i++) begin
      buf_rd(3 * REGION + i, b);
      if (i < BB && b !== 8'h00) bad++;
      if (i >= BB && b !== 8'h40 + 8'(r0 + i - BB)) bad++;
    end
    chk(bad, 0, "R8 spare bytes only");
    reg_wr(3'd4, 16'h0000);
    reg_wr(3'd3, 16'h0000);

    // ID read lands in buffer 0 despite index 3
    for (int i = 0; i < 8; i++) buf_wr(i, 8'h00);
    r0 = rd_n;
    reg_wr(3'd3, 16'h0010);
    wait_idle();
    bad = 0;
    for (int i = 0; i < IDB; i++) begin
      buf_rd(i, b);
      if (b !== 8'h40 + 8'(r0 + i)) bad++;
    end
    chk(bad, 0, "R4 ID bytes at buffer 0");
    buf_rd(IDB, b); chk(b, 8'h00, "R4 byte after ID untouched");
    reg_wr(3'd3, 16'h0000);

    // status read: one byte at offset 0
    r0 = rd_n;
    reg_wr(3'd3, 16'h0020);
    wait_idle();
    buf_rd(0, b); chk(b, 8'h40 + 8'(r0), "R4 status byte");
    buf_rd(1, b); chk(b, 8'h40 + 8'(r0 - IDB + 1), "R4 status leaves byte 1");
    reg_rd(3'd3, v); chk(v, 16'h8000, "R5 status done");

    // several op bits: nothing starts, done still cleared
    n0 = log_n;
    reg_wr(3'd3, 16'h0003);
    @(negedge clk);
    reg_rd(3'd3, v); chk(v, 16'h0000, "R12 multi-bit write starts nothing");
    chk(log_n - n0, 0, "R12 no strobe on multi-bit write");

    // flash reset command
    reg_wr(3'd0, 16'h00FF);
    rb = 1'b0;
    n0 = log_n;
    reg_wr(3'd3, 16'h0001);
    repeat (20) @(negedge clk);
    reg_rd(3'd3, v); chk(v, 16'h0001, "R6 reset waits for ready");
    chk(logv[n0], {2'b10, 8'hFF}, "R6 reset command latched");
    rb = 1'b1;
    wait_idle();
    @(negedge clk);
    reg_rd(3'd3, v); chk(v, 16'h0000, "R6 reset completes with zero");
    chk(irq, 0, "R6 R9 no irq for reset");

    // soft reset aborts a waiting phase
    rb = 1'b0;
    reg_wr(3'd3, 16'h0008);
    reg_wr(3'd4, 16'h0040);
    reg_rd(3'd3, v); chk(v, 16'h0000, "R11 soft reset clears control");
    reg_rd(3'd4, v); chk(v, 16'h0000, "R11 soft reset bit self-clears");
    chk(ce_n, 1, "R10 chip enable released");
    r0 = rd_n;
    rb = 1'b1;
    repeat (10) @(negedge clk);
    chk(rd_n - r0, 0, "R11 no reads after abort");

    // forced chip enable
    reg_wr(3'd4, 16'h0080);
    chk(ce_n, 0, "R10 forced chip enable");
    reg_rd(3'd4, v); chk(v, 16'h0080, "R11 force bit readback");
    reg_wr(3'd4, 16'h0000);
    chk(ce_n, 1, "R10 chip enable off");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule